// File: doc/BRIEF.md
# Programmable PAL Vertical Sync Generator

This block produces the vertical sync output, the field flag and the V bit for the embedded timing code of a 625-line interlaced video stream. It runs on the pixel clock. It follows the position in the frame from three strobes: a frame-start marker, a line-start strobe and a mid-line strobe. From these it keeps a line counter and a half-line flag.

Each field has a nominal boundary line. Field 1 (the odd field) starts at line 1, and field 2 (the even field) starts at line 313. The rising edge of vsync sits a programmable number of lines before or after that boundary, depending on a sign control. Each field can also add its own extra delay of either one line or half a line. The falling edge of vsync and the field-flag change sit at programmable line offsets after the boundary.

All control values are captured together at the frame-start marker. A change made part-way through a frame therefore waits for the next frame. The VS output and the V bit are driven from the same decision and never differ.

Top module: `pal_vsync_gen`

## Requirements
- R1: Line position tracking.
  - A frame-start strobe places the position at line 1, first half.
  - A line-start strobe advances to the first half of the next line, and after line 625 it wraps to line 1 even without a frame-start strobe.
  - A mid-line strobe moves to the second half of the current line.
  - A frame-start strobe overrides the other two strobes.
- R2: Reset values.
  - After reset, `vs_o`, `vbit_o` and `field_o` are 0 and the position is line 1, first half.
  - The captured controls take these values: begin offset 5, sign 1 (advance), odd delay 0, even delay 1, both half-step selects 0, end offset 4, toggle offset 6.
- R3: Vsync begin line. The vsync rising edge is placed at nominal line minus the begin offset when the sign is 1, or nominal line plus the offset when the sign is 0, wrapping within the 625-line frame. The nominal line is 1 for field 1 and 313 for field 2.
- R4: Odd-field delay. When the odd-field delay is 1, the field-1 rising edge is postponed by one line, or by half a line (to mid-line) when the odd half-step select is 1.
- R5: Even-field delay. When the even-field delay is 1, the field-2 rising edge is postponed by one line, or by half a line when the even half-step select is 1.
- R6: Vsync end line.
  - Vsync falls at the start of line (nominal + end offset) of each field.
  - When a begin position equals an end position, the end wins and vsync stays low there.
- R7: Field flag. `field_o` becomes 0 at the start of line (1 + toggle offset) and 1 at the start of line (313 + toggle offset). It changes at no other position.
- R8: `vbit_o` equals `vs_o` on every clock.
- R9: Capture timing.
  - The controls are captured only in a cycle where `frame_stb` is 1.
  - Changes to the control inputs at any other time have no effect on the outputs until the next frame start.
- R10: Output timing. An output change caused by a strobe appears on the second rising clock edge that samples the strobe high, counting that edge as the first. Outputs never change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse at each line start |
| half_stb | input | 1 | One-cycle pulse at mid-line |
| frame_stb | input | 1 | One-cycle pulse at the start of line 1; also captures the controls |
| vb_off_i | input | OFF_W | Vsync begin offset in lines |
| vb_adv_i | input | 1 | Begin direction: 1 advances (earlier), 0 delays (later) |
| odd_dly_i | input | 1 | Extra begin delay on field 1 |
| odd_half_i | input | 1 | Field-1 extra delay step: 1 = half line, 0 = full line |
| even_dly_i | input | 1 | Extra begin delay on field 2 |
| even_half_i | input | 1 | Field-2 extra delay step: 1 = half line, 0 = full line |
| ve_off_i | input | OFF_W | Vsync end offset in lines after the field boundary |
| ft_off_i | input | OFF_W | Field-flag toggle offset in lines after the field boundary |
| vs_o | output | 1 | Vertical sync output |
| vbit_o | output | 1 | V bit for the embedded timing code |
| field_o | output | 1 | Field flag: 0 = field 1, 1 = field 2 |

## Verification
The bench builds the block with its default parameters: 625 lines and 5-bit offsets. This keeps the real PAL boundary lines, 313 and 625, and wraps of advanced begin positions around line 1 within reach. With half-line segments four clocks long, six frames fit in about 30,000 cycles.

Those six frames cover:
- the reset controls, used without any frame-start capture;
- delayed and advanced begins;
- full-line and half-line steps on each field;
- a begin that coincides with its end;
- a mid-frame control change;
- a frame that wraps only through the line strobe.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
  localparam int DEF_VB_OFF    = 5;
  localparam bit DEF_VB_ADV    = 1'b1;
  localparam bit DEF_ODD_DLY   = 1'b0;
  localparam bit DEF_ODD_HALF  = 1'b0;
  localparam bit DEF_EVEN_DLY  = 1'b1;
  localparam bit DEF_EVEN_HALF = 1'b0;
  localparam int DEF_VE_OFF    = 4;
  localparam int DEF_FT_OFF    = 6;

  // Bring a half-line index back into [0, period) after a single over- or underflow.
  function automatic int wrap_h(input int v, input int period);
    int r;
    r = v;
    if (r < 0) r = r + period;
    if (r >= period) r = r - period;
    return r;
  endfunction
endpackage

// File: rtl/pvs_line_track.sv
module pvs_line_track #(
  parameter int LINES = 625,
  parameter int HW    = $clog2(4 * LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_stb,
  input  logic          half_stb,
  input  logic          frame_stb,
  output logic [HW-1:0] hpos,
  output logic          ev
);
  localparam int LW = $clog2(LINES + 1);

  logic [LW-1:0] ln;
  logic          half;

  always_ff @(posedge clk) begin
    if (rst) begin
      ln   <= LW'(1);
      half <= 1'b0;
      ev   <= 1'b0;
    end else begin
      ev <= frame_stb | line_stb | half_stb;
      if (frame_stb) begin
        ln   <= LW'(1);
        half <= 1'b0;
      end else if (line_stb) begin
        ln   <= (ln == LW'(LINES)) ? LW'(1) : ln + LW'(1);
        half <= 1'b0;
      end else if (half_stb) begin
        half <= 1'b1;
      end
    end
  end

  // Half-line index: 2*(line-1) + half
  always_comb hpos = HW'({ln - LW'(1), half});

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> (ln == LW'(1) && !half)); // R1
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (line_stb && !frame_stb && ln == LW'(LINES)) |=> (ln == LW'(1))); // R1
endmodule

// File: rtl/pvs_field_edges.sv
module pvs_field_edges #(
  parameter int LINES    = 625,
  parameter int OFF_W    = 5,
  parameter int NOM_LINE = 1,
  parameter int HW       = $clog2(4 * LINES)
) (
  input  logic [OFF_W-1:0] b_off,
  input  logic             adv,
  input  logic             dly,
  input  logic             hstep,
  input  logic [OFF_W-1:0] e_off,
  input  logic [OFF_W-1:0] t_off,
  output logic [HW-1:0]    beg_h,
  output logic [HW-1:0]    end_h,
  output logic [HW-1:0]    tog_h
);
  import pvs_pkg::*;

  localparam int NOM_H   = 2 * (NOM_LINE - 1);
  localparam int FRAME_H = 2 * LINES;

  always_comb begin
    int b;
    b = adv ? NOM_H - 2 * int'(b_off) : NOM_H + 2 * int'(b_off);
    if (dly) b = b + (hstep ? 1 : 2);
    beg_h = HW'(wrap_h(b, FRAME_H));
    end_h = HW'(wrap_h(NOM_H + 2 * int'(e_off), FRAME_H));
    tog_h = HW'(wrap_h(NOM_H + 2 * int'(t_off), FRAME_H));
  end
endmodule

// File: rtl/pal_vsync_gen.sv
module pal_vsync_gen #(
  parameter int LINES = 625,
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_stb,
  input  logic             half_stb,
  input  logic             frame_stb,
  input  logic [OFF_W-1:0] vb_off_i,
  input  logic             vb_adv_i,
  input  logic             odd_dly_i,
  input  logic             odd_half_i,
  input  logic             even_dly_i,
  input  logic             even_half_i,
  input  logic [OFF_W-1:0] ve_off_i,
  input  logic [OFF_W-1:0] ft_off_i,
  output logic             vs_o,
  output logic             vbit_o,
  output logic             field_o
);
  import pvs_pkg::*;

  localparam int HW          = $clog2(4 * LINES);
  localparam int FIELD2_LINE = (LINES + 1) / 2;

  // Controls captured at frame start
  logic [OFF_W-1:0] sh_boff, sh_eoff, sh_toff;
  logic             sh_adv, sh_odly, sh_ohalf, sh_edly, sh_ehalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_boff  <= OFF_W'(DEF_VB_OFF);
      sh_adv   <= DEF_VB_ADV;
      sh_odly  <= DEF_ODD_DLY;
      sh_ohalf <= DEF_ODD_HALF;
      sh_edly  <= DEF_EVEN_DLY;
      sh_ehalf <= DEF_EVEN_HALF;
      sh_eoff  <= OFF_W'(DEF_VE_OFF);
      sh_toff  <= OFF_W'(DEF_FT_OFF);
    end else if (frame_stb) begin
      sh_boff  <= vb_off_i;
      sh_adv   <= vb_adv_i;
      sh_odly  <= odd_dly_i;
      sh_ohalf <= odd_half_i;
      sh_edly  <= even_dly_i;
      sh_ehalf <= even_half_i;
      sh_eoff  <= ve_off_i;
      sh_toff  <= ft_off_i;
    end
  end

  logic [HW-1:0] hpos;
  logic          ev;

  pvs_line_track #(.LINES(LINES), .HW(HW)) u_track (
    .clk      (clk),
    .rst      (rst),
    .line_stb (line_stb),
    .half_stb (half_stb),
    .frame_stb(frame_stb),
    .hpos     (hpos),
    .ev       (ev)
  );

  logic [HW-1:0] beg_h [2];
  logic [HW-1:0] end_h [2];
  logic [HW-1:0] tog_h [2];

  for (genvar g = 0; g < 2; g++) begin : g_field
    localparam int NL = (g == 0) ? 1 : FIELD2_LINE;
    pvs_field_edges #(.LINES(LINES), .OFF_W(OFF_W), .NOM_LINE(NL), .HW(HW)) u_edges (
      .b_off(sh_boff),
      .adv  (sh_adv),
      .dly  ((g == 0) ? sh_odly  : sh_edly),
      .hstep((g == 0) ? sh_ohalf : sh_ehalf),
      .e_off(sh_eoff),
      .t_off(sh_toff),
      .beg_h(beg_h[g]),
      .end_h(end_h[g]),
      .tog_h(tog_h[g])
    );
  end

  logic hit_beg, hit_end, hit_t1, hit_t2;
  always_comb begin
    hit_beg = ev && (hpos == beg_h[0] || hpos == beg_h[1]);
    hit_end = ev && (hpos == end_h[0] || hpos == end_h[1]);
    hit_t1  = ev && (hpos == tog_h[0]);
    hit_t2  = ev && (hpos == tog_h[1]);
  end

  logic vs_q, vb_q, fld_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q  <= 1'b0;
      vb_q  <= 1'b0;
      fld_q <= 1'b0;
    end else begin
      if (hit_end) begin
        vs_q <= 1'b0;
        vb_q <= 1'b0;
      end else if (hit_beg) begin
        vs_q <= 1'b1;
        vb_q <= 1'b1;
      end
      if (hit_t1)      fld_q <= 1'b0;
      else if (hit_t2) fld_q <= 1'b1;
    end
  end

  assign vs_o    = vs_q;
  assign vbit_o  = vb_q;
  assign field_o = fld_q;

  AST_VS_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_q) |-> $past(ev)); // R10
  AST_FIELD_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(fld_q) |-> $past(ev)); // R7
  AST_END_WINS: assert property (@(posedge clk) disable iff (rst)
    (ev && (hpos == end_h[0] || hpos == end_h[1])) |=> !vs_q); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable({sh_boff, sh_adv, sh_odly, sh_ohalf, sh_edly,
                            sh_ehalf, sh_eoff, sh_toff})); // R9
endmodule

// File: tb/tb_pal_vsync_gen.sv
module tb_pal_vsync_gen;
  localparam int LINES = 625;
  localparam int OFF_W = 5;
  localparam int H     = 4;   // clocks per half line
  localparam int FH    = 2 * LINES;

  logic clk = 1'b0, rst = 1'b1;
  logic line_stb = 0, half_stb = 0, frame_stb = 0;
  logic [OFF_W-1:0] vb_off = 0, ve_off = 0, ft_off = 0;
  logic vb_adv = 0, odd_dly = 0, odd_half = 0, even_dly = 0, even_half = 0;
  logic vs_o, vbit_o, field_o;

  always #10 clk = ~clk;   // 50 MHz

  pal_vsync_gen #(.LINES(LINES), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst(rst), .line_stb(line_stb), .half_stb(half_stb),
    .frame_stb(frame_stb), .vb_off_i(vb_off), .vb_adv_i(vb_adv),
    .odd_dly_i(odd_dly), .odd_half_i(odd_half), .even_dly_i(even_dly),
    .even_half_i(even_half), .ve_off_i(ve_off), .ft_off_i(ft_off),
    .vs_o(vs_o), .vbit_o(vbit_o), .field_o(field_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Behavioural reference model (half-line arithmetic on integers)
  int m_ln, m_half, m_p;
  bit m_ev;
  int s_off, s_eoff, s_toff;
  bit s_adv, s_od, s_oh, s_ed, s_eh;
  bit e_vs, e_fld;

  function automatic int mbeg(input int nom_line, input bit d, input bit hs);
    int b;
    b = 2 * (nom_line - 1) + (s_adv ? -2 * s_off : 2 * s_off);
    if (d) b += hs ? 1 : 2;
    return ((b % FH) + FH) % FH;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ln = 1; m_half = 0; m_ev = 0;
      s_off = 5; s_adv = 1; s_od = 0; s_oh = 0; s_ed = 1; s_eh = 0; s_eoff = 4; s_toff = 6;
      e_vs = 0; e_fld = 0;
    end else begin
      if (m_ev) begin
        m_p = 2 * (m_ln - 1) + m_half;
        if (m_p == (2 * s_eoff) % FH || m_p == (624 + 2 * s_eoff) % FH) e_vs = 0;
        else if (m_p == mbeg(1, s_od, s_oh) || m_p == mbeg(313, s_ed, s_eh)) e_vs = 1;
        if (m_p == 2 * s_toff) e_fld = 0;
        else if (m_p == 624 + 2 * s_toff) e_fld = 1;
      end
      m_ev = frame_stb | line_stb | half_stb;
      if (frame_stb) begin
        m_ln = 1; m_half = 0;
        s_off = vb_off; s_adv = vb_adv; s_od = odd_dly; s_oh = odd_half;
        s_ed = even_dly; s_eh = even_half; s_eoff = ve_off; s_toff = ft_off;
      end else if (line_stb) begin
        m_ln = (m_ln == LINES) ? 1 : m_ln + 1; m_half = 0;
      end else if (half_stb) m_half = 1;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(vs_o, e_vs, "R3/R4/R5/R6/R10 vs_o vs model");
      chk(field_o, e_fld, "R7 field_o vs model");
      chk(vbit_o, vs_o, "R8 vbit_o equals vs_o");
    end
  end

  // Event records per frame, encoded as line*2+half
  int rise_c, fall_c, rise_p[4], fall_p[4], fr_p, ff_p, fr_c, ff_c;
  bit p_vs, p_fld;

  task automatic set_ctrl(input int off, input bit adv, input bit od, input bit oh,
                          input bit ed, input bit eh, input int ve, input int ft);
    vb_off = OFF_W'(off); vb_adv = adv; odd_dly = od; odd_half = oh;
    even_dly = ed; even_half = eh; ve_off = OFF_W'(ve); ft_off = OFF_W'(ft);
  endtask

  task automatic seg_sample(input int ln, input int hf);
    if (vs_o && !p_vs) begin if (rise_c < 4) rise_p[rise_c] = ln * 2 + hf; rise_c++; end
    if (!vs_o && p_vs) begin if (fall_c < 4) fall_p[fall_c] = ln * 2 + hf; fall_c++; end
    if (field_o && !p_fld) begin fr_p = ln * 2 + hf; fr_c++; end
    if (!field_o && p_fld) begin ff_p = ln * 2 + hf; ff_c++; end
    p_vs = vs_o; p_fld = field_o;
  endtask

  // kind: 0 = no strobe at line 1, 1 = frame_stb, 2 = line_stb only
  task automatic run_frame(input int kind, input bit mid_change);
    rise_c = 0; fall_c = 0; fr_c = 0; ff_c = 0; fr_p = -1; ff_p = -1;
    for (int i = 0; i < 4; i++) begin rise_p[i] = -1; fall_p[i] = -1; end
    for (int ln = 1; ln <= LINES; ln++) begin
      if (mid_change && ln == 100) set_ctrl(3, 0, 0, 0, 0, 0, 3, 6);
      @(negedge clk);
      if (ln == 1 && kind == 1) frame_stb = 1;
      else if (!(ln == 1 && kind == 0)) line_stb = 1;
      @(negedge clk);
      frame_stb = 0; line_stb = 0;
      repeat (H - 1) @(negedge clk);
      seg_sample(ln, 0);
      half_stb = 1;
      @(negedge clk);
      half_stb = 0;
      repeat (H - 1) @(negedge clk);
      seg_sample(ln, 1);
    end
  endtask

  task automatic chk_frame(input int nr, input int r0, input int r1,
                           input int nf, input int f0, input int f1, input string tag);
    chk(rise_c, nr, {tag, " rise count"});
    if (nr > 0) chk(rise_p[0], r0, {tag, " first rise line*2+half"});
    if (nr > 1) chk(rise_p[1], r1, {tag, " second rise line*2+half"});
    chk(fall_c, nf, {tag, " fall count"});
    if (nf > 0) chk(fall_p[0], f0, {tag, " first fall line*2+half"});
    if (nf > 1) chk(fall_p[1], f1, {tag, " second fall line*2+half"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(vs_o, 0, "R2 reset vs_o");
    chk(vbit_o, 0, "R2 reset vbit_o");
    chk(field_o, 0, "R2 reset field_o");
    p_vs = vs_o; p_fld = field_o;

    // Frame 1: reset controls only; inputs hold other values (R2, R9)
    set_ctrl(0, 0, 1, 1, 0, 1, 9, 9);
    run_frame(0, 0);
    chk_frame(2, 618, 1242, 1, 634, 0, "R2/R3/R5 defaults frame");
    chk(fr_p, 638, "R7 field rises at line 319");
    chk(ff_c, 0, "R7 no field fall when already 0");

    // Frame 2: delayed begin 1, odd half step, even full step
    set_ctrl(1, 0, 1, 1, 1, 0, 4, 6);
    run_frame(1, 0);
    chk_frame(1, 630, 0, 2, 10, 634, "R3/R5/R6 delayed begin frame");
    chk(ff_p, 14, "R7 field falls at line 7");

    // Frame 3: same controls; inputs change at line 100 (R9)
    run_frame(1, 1);
    chk_frame(2, 5, 630, 2, 10, 634, "R4/R9 odd half step, mid-frame change ignored");

    // Frame 4: begin equals end (R6)
    run_frame(1, 0);
    chk_frame(0, 0, 0, 0, 0, 0, "R6 begin equals end gives no pulse");
    chk(ff_p, 14, "R7 field fall frame 4");
    chk(fr_p, 638, "R7 field rise frame 4");

    // Frame 5: advance 2, even half step, toggle 10
    set_ctrl(2, 1, 0, 0, 1, 1, 4, 10);
    run_frame(1, 0);
    chk_frame(2, 623, 1248, 1, 634, 0, "R3/R5 advance with even half step");
    chk(ff_p, 22, "R7 field falls at line 11");
    chk(fr_p, 646, "R7 field rises at line 323");

    // Frame 6: wrap by line strobe only (R1)
    run_frame(2, 0);
    chk_frame(2, 623, 1248, 2, 10, 634, "R1 wrap without frame strobe");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule